// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Per-Set LRU

This block sits between a processor's load/store port and a slower backing memory. It keeps eight 32-bit words, organised as four sets that each hold two one-word ways. Each request carries a byte address. The cache takes the set number from the address bits just above the byte offset and uses the upper bits as the tag. It checks both ways of that set at once. A load that hits returns its word in the same cycle.

A load that misses holds the processor with `stall`. The cache then reads the word from the backing memory over a request/acknowledge handshake. In the acknowledge cycle the word goes to the processor and is written into the set. Stores always go through to the backing memory. A store that misses also allocates the word into the cache.

Each set has one replacement bit that names the way it used least recently. Two addresses that share a set can therefore stay resident together. Two running counters report completed hits and misses, so miss rates can be measured.

Top module: `dual_way_cache`

## Requirements
- R1: The address splits as byte offset in bits [1:0], set number in bits [3:2] and tag in bits [31:4]. Two addresses that differ only in bits [1:0] refer to the same cached word.
- R2: A load that hits completes in the cycle it is presented. In that cycle `rsp_valid` is 1, `stall` is 0, `mem_req` is 0, and `rsp_rdata` carries the cached word.
- R3: A load that misses drives `stall`=1 and `mem_req`=1 with `mem_write`=0 and `mem_addr` equal to the request address, until `mem_ack`. In the acknowledge cycle `rsp_valid`=1, `stall`=0 and `rsp_rdata` equals `mem_rdata`.
- R4: The word fetched on a load miss is installed, so the next load of the same word hits without a memory request.
- R5: Two tags that map to the same set stay resident together. Alternating loads of 0x04 and 0x24, five each, give exactly 2 misses and 8 hits.
- R6: Reset clears every valid bit, so the first access to any word after reset misses. A miss fills an empty way of the set before any valid way is evicted.
- R7: When both ways of a set are valid, a miss replaces the way used least recently. Both hits and fills count as uses.
- R8: Every store is written through. It drives `mem_req`=1, `mem_write`=1, `mem_addr` equal to the request address and `mem_wdata` equal to `req_wdata`, with `stall`=1 until `mem_ack`. A store hit also updates the cached word.
- R9: A store miss allocates its word into the set using the same victim choice as a load miss, so a following load of that address hits and returns the stored data.
- R10: `hit_count` and `miss_count` are 0 after reset. Each completed access adds exactly one to the counter that matches its outcome, and neither counter changes in any other cycle.
- R11: Sets are independent: filling or replacing entries in one set never evicts an entry of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor access present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Load data (store data echoed on a store) |
| stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Backing memory request |
| mem_write | output | 1 | Backing memory request is a write |
| mem_addr | output | 32 | Backing memory byte address |
| mem_wdata | output | 32 | Backing memory write data |
| mem_ack | input | 1 | Backing memory done; read data valid |
| mem_rdata | input | 32 | Backing memory read data |
| hit_count | output | 16 | Completed hits since reset |
| miss_count | output | 16 | Completed misses since reset |

## Verification
The assertions take two things for granted:
- The processor keeps `req_valid`, `req_write`, `req_addr` and `req_wdata` unchanged for as long as `stall` is high.
- The backing memory raises `mem_ack` only while `mem_req` is high, and presents `mem_rdata` in that same cycle.

The stimulus meets both conditions by construction:
- Each access is driven by one task call. The task holds its inputs from the first cycle until the cycle the access completes.
- The model raises `mem_ack` only on accesses it predicts will need memory, after a chosen latency of zero to three cycles.

// File: rtl/dwc_pkg.sv
`timescale 1ns/1ps
package dwc_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WAYS   = 2;
    localparam int SETS   = 4;
    localparam int CNT_W  = 16;
    localparam int OFS_W  = 2;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_RD_HIT,
        ACC_MEM_WAIT,
        ACC_MEM_DONE
    } acc_kind_t;

    typedef struct packed {
        logic hit;
        logic hit_way;
        logic tgt_way;
    } pick_t;

    function automatic idx_t set_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction
endpackage

// File: rtl/dwc_way_store.sv
`timescale 1ns/1ps
module dwc_way_store #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    localparam int IW    = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IW-1:0]     idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            data_q[idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_data  = data_q[idx];
endmodule

// File: rtl/dwc_lru.sv
`timescale 1ns/1ps
module dwc_lru #(
    parameter int SETS = 4,
    localparam int IW  = $clog2(SETS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] idx,
    input  logic          touch,
    input  logic          touched_way,
    output logic          lru_way
);
    logic [SETS-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else if (touch) begin
            older_q[idx] <= ~touched_way;
        end
    end

    assign lru_way = older_q[idx];
endmodule

// File: rtl/dwc_ctrl.sv
`timescale 1ns/1ps
module dwc_ctrl
    import dwc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    way_valid,
    input  logic [1:0]    way_match,
    input  logic          lru_way,
    input  logic          mem_ack,
    output acc_kind_t     kind,
    output pick_t         pick,
    output logic          need_mem,
    output logic          done,
    output logic          install,
    output logic [CW-1:0] hit_count,
    output logic [CW-1:0] miss_count
);
    logic victim;
    logic [CW-1:0] hits_q, misses_q;

    always_comb begin
        if (!way_valid[0])      victim = 1'b0;
        else if (!way_valid[1]) victim = 1'b1;
        else                    victim = lru_way;
        pick.hit     = |way_match;
        pick.hit_way = way_match[1];
        pick.tgt_way = pick.hit ? pick.hit_way : victim;
    end

    always_comb begin
        need_mem = req_valid && (req_write || !pick.hit);
        if (!req_valid)   kind = ACC_NONE;
        else if (!need_mem) kind = ACC_RD_HIT;
        else if (mem_ack) kind = ACC_MEM_DONE;
        else              kind = ACC_MEM_WAIT;
        done    = (kind == ACC_RD_HIT) || (kind == ACC_MEM_DONE);
        install = (kind == ACC_MEM_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hits_q   <= '0;
            misses_q <= '0;
        end else if (done) begin
            if (pick.hit) hits_q   <= hits_q + CW'(1);
            else          misses_q <= misses_q + CW'(1);
        end
    end

    assign hit_count  = hits_q;
    assign miss_count = misses_q;
endmodule

// File: rtl/dual_way_cache.sv
`timescale 1ns/1ps
module dual_way_cache
    import dwc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              stall,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CW-1:0]     hit_count,
    output logic [CW-1:0]     miss_count
);
    idx_t      idx;
    tag_t      tag;
    word_t     fill_data;
    logic [WAYS-1:0] way_valid, way_match, way_we;
    tag_t      way_tag  [WAYS];
    word_t     way_data [WAYS];
    logic      lru_way;
    acc_kind_t kind;
    pick_t     pick;
    logic      need_mem, done, install;

    assign idx       = set_of(req_addr);
    assign tag       = tag_of(req_addr);
    assign fill_data = req_write ? req_wdata : mem_rdata;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        dwc_way_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
            .clk(clk), .rst(rst), .idx(idx),
            .rd_valid(way_valid[w]), .rd_tag(way_tag[w]), .rd_data(way_data[w]),
            .wr_en(way_we[w]), .wr_tag(tag), .wr_data(fill_data)
        );
        assign way_match[w] = way_valid[w] && (way_tag[w] == tag);
        assign way_we[w]    = install && (pick.tgt_way == 1'(w));
    end

    dwc_lru #(.SETS(SETS)) u_lru (
        .clk(clk), .rst(rst), .idx(idx),
        .touch(done), .touched_way(pick.tgt_way), .lru_way(lru_way)
    );

    dwc_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .way_valid(way_valid), .way_match(way_match), .lru_way(lru_way),
        .mem_ack(mem_ack), .kind(kind), .pick(pick),
        .need_mem(need_mem), .done(done), .install(install),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    assign rsp_valid = done;
    assign stall     = (kind == ACC_MEM_WAIT);
    assign mem_req   = need_mem;
    assign mem_write = req_write;
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;
    assign rsp_rdata = req_write ? req_wdata :
                       (pick.hit ? way_data[pick.hit_way] : mem_rdata);
endmodule

// File: rtl/dwc_chk.sv
`timescale 1ns/1ps
module dwc_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic [31:0]   req_addr,
    input logic [31:0]   req_wdata,
    input logic          rsp_valid,
    input logic [31:0]   rsp_rdata,
    input logic          stall,
    input logic          mem_req,
    input logic          mem_write,
    input logic [31:0]   mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic [31:0]   mem_rdata,
    input logic [CW-1:0] hit_count,
    input logic [CW-1:0] miss_count
);
    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (rsp_valid != stall));

    assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!stall && !rsp_valid && !mem_req));

    assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !mem_req) |-> (rsp_valid && !stall));

    assert_fill_return_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !req_write) |-> (rsp_valid && rsp_rdata == mem_rdata));

    assert_mem_addr_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr == req_addr));

    assert_store_through_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> (mem_req && mem_write && mem_wdata == req_wdata));

    assert_counts_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> ($stable(hit_count) && $stable(miss_count)));

    assert_counts_step_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> ((hit_count == $past(hit_count) + CW'(1)) !=
                       (miss_count == $past(miss_count) + CW'(1))));

    assert_load_miss_counted_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !req_write && mem_req) |=> (miss_count == $past(miss_count) + CW'(1)));
endmodule

bind dual_way_cache dwc_chk #(.CW(CW)) u_dwc_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .stall(stall), .mem_req(mem_req),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/dual_way_cache_tb_top.sv
`timescale 1ns/1ps
module dual_way_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_valid, stall, mem_req, mem_write;
    logic [31:0] rsp_rdata, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] hit_count, miss_count;

    always #2.5 clk = ~clk;

    dual_way_cache dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .stall(stall), .mem_req(mem_req),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference: per-set way records with use timestamps
    bit          m_valid [4][2];
    int unsigned m_tag   [4][2];
    int unsigned m_data  [4][2];
    longint      m_used  [4][2];
    longint      m_time = 0;
    int unsigned backing [int unsigned];
    int          m_hits = 0, m_misses = 0;

    function automatic int unsigned bk_get(input int unsigned a);
        if (backing.exists(a >> 2)) return backing[a >> 2];
        return (a & 32'hFFFF_FFFC) ^ 32'hA5C3_0000;
    endfunction

    task automatic check(input string r, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic do_reset(input string r);
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; mem_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) m_valid[s][w] = 1'b0;
        m_hits = 0; m_misses = 0;
        #1;
        check(r, "hit_count after reset", hit_count, 0);
        check(r, "miss_count after reset", miss_count, 0);
        check(r, "stall idle", stall, 0);
        check(r, "rsp_valid idle", rsp_valid, 0);
        check(r, "mem_req idle", mem_req, 0);
    endtask

    task automatic access(input string r, input bit wr, input int unsigned a,
                          input int unsigned wd, input int lat);
        int s, hw, waited, vic;
        bit need, ack, fin;
        int unsigned tg, exp_rd;
        s = (a >> 2) & 3;
        tg = a >> 4;
        hw = -1;
        for (int w = 0; w < 2; w++)
            if (m_valid[s][w] && m_tag[s][w] == tg) hw = w;
        need = wr || (hw < 0);
        waited = 0;
        fin = 1'b0;
        while (!fin) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
            ack = need && (waited >= lat);
            mem_ack = ack;
            mem_rdata = ack ? bk_get(a) : (32'hBAD0_0000 ^ waited);
            #1;
            fin = !need || ack;
            check(r, "stall", stall, need && !ack);
            check(r, "rsp_valid", rsp_valid, fin);
            check(r, "mem_req", mem_req, need);
            if (need) begin
                check(r, "mem_write", mem_write, wr);
                check(r, "mem_addr", mem_addr, a);
                if (wr) check(r, "mem_wdata", mem_wdata, wd);
            end
            if (fin) begin
                exp_rd = wr ? wd : (hw >= 0 ? m_data[s][hw] : bk_get(a));
                check(r, "rsp_rdata", rsp_rdata, exp_rd);
            end
            check(r, "hit_count", hit_count, m_hits);
            check(r, "miss_count", miss_count, m_misses);
            @(posedge clk);
            if (!fin) waited++;
        end
        m_time++;
        if (hw >= 0) begin
            m_hits++;
            if (wr) m_data[s][hw] = wd;
            m_used[s][hw] = m_time;
        end else begin
            m_misses++;
            if (!m_valid[s][0])      vic = 0;
            else if (!m_valid[s][1]) vic = 1;
            else                     vic = (m_used[s][0] < m_used[s][1]) ? 0 : 1;
            m_valid[s][vic] = 1'b1;
            m_tag[s][vic]   = tg;
            m_data[s][vic]  = wr ? wd : bk_get(a);
            m_used[s][vic]  = m_time;
        end
        if (wr) backing[a >> 2] = wd;
    endtask

    task automatic expect_counts(input string r, input int h, input int m);
        @(negedge clk);
        req_valid = 1'b0; mem_ack = 1'b0;
        #1;
        check(r, "hit total", hit_count, h);
        check(r, "miss total", miss_count, m);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5 * 100000);
        n_bad++;
        $display("FAIL R3 watchdog: actual=hung expected=completion");
        summary();
    end

    initial begin
        do_reset("R10");
        // R6: empty cache misses
        access("R6", 0, 32'h04, 0, 1);
        // R3: miss with longer latency
        access("R3", 0, 32'h10, 0, 3);
        // R4 / R2: refetch hits without memory
        access("R4", 0, 32'h10, 0, 0);
        access("R2", 0, 32'h04, 0, 0);
        // R1: byte offset bits select the same word
        access("R1", 0, 32'h13, 0, 0);
        access("R1", 0, 32'h06, 0, 0);
        expect_counts("R10", 4, 2);

        // R5: 0x04 / 0x24 alternated five times each
        do_reset("R5");
        for (int i = 0; i < 5; i++) begin
            access("R5", 0, 32'h04, 0, 2);
            access("R5", 0, 32'h24, 0, 2);
        end
        expect_counts("R5", 8, 2);

        // R7: third tag in set 1 evicts 0x04 (least recently used)
        access("R7", 0, 32'h44, 0, 1);
        access("R7", 0, 32'h24, 0, 1);
        access("R7", 0, 32'h04, 0, 1);
        access("R7", 0, 32'h24, 0, 1);
        expect_counts("R7", 10, 4);

        // R8: store hit written through and updates cached word
        access("R8", 1, 32'h24, 32'hCAFE_0024, 2);
        access("R8", 0, 32'h24, 0, 0);
        // R9: store miss allocates
        access("R9", 1, 32'h88, 32'h1234_5678, 1);
        access("R9", 0, 32'h88, 0, 0);

        // R11: fill every set with two tags, all must still hit
        do_reset("R11");
        for (int s = 0; s < 4; s++) begin
            access("R11", 0, s * 4, 0, 1);
            access("R11", 0, 32'h100 + s * 4, 0, 1);
        end
        for (int s = 0; s < 4; s++) begin
            access("R11", 0, s * 4, 0, 0);
            access("R11", 0, 32'h100 + s * 4, 0, 0);
        end
        expect_counts("R11", 8, 8);

        // R6: reset drops contents
        do_reset("R6");
        access("R6", 0, 32'h00, 0, 0);
        expect_counts("R6", 0, 1);

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int unsigned a;
            bit wr;
            a  = ($urandom_range(0, 5) << 4) | ($urandom_range(0, 3) << 2) | $urandom_range(0, 3);
            wr = ($urandom_range(0, 3) == 0);
            access(wr ? "R8" : "R7", wr, a, $urandom, $urandom_range(0, 3));
        end
        expect_counts("R10", m_hits, m_misses);
        summary();
    end
endmodule